// File: doc/BRIEF.md
# Reversible-Gate Synchronous Up Counter

An N-bit synchronous up counter whose next-state logic is made only of reversible multi-control Toffoli gates. A Feynman gate is the one-control case. The count input `c_i` and the present state drive one gate per bit. Bit 0 takes a one-control gate. Bit i takes an (i+1)-control Toffoli whose controls are `c_i` and bits 0 to i-1, and whose target is bit i. The gates are applied from the top bit down, so every control sees the present state.

Each next-state line is duplicated by a Feynman gate whose target starts at constant 0. That copy is registered and fed back as the present state. The cost of the wide Toffolis comes from a chain of ancilla lines holding partial products. Those lines are not restored, so they leave the block as garbage. The pass-through `c_i` line is garbage as well. A static tally of gate cost is also driven out: a 1- or 2-line gate counts 1, and a Toffoli with k ≥ 2 controls counts 5·(k−1).

Top module: `rev_up_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0, asynchronously.
- R2: On a rising clock edge with `c_i` = 0, `count_o` keeps its value.
- R3: On a rising clock edge with `c_i` = 1, `count_o` becomes its previous value plus one, modulo 2^N.
- R4: With `count_o` all ones and `c_i` = 1, the next value is 0.
- R5: `garbage_o[0]` always equals `c_i`.
- R6: For each bit i ≥ 2, garbage bits starting at offset 1+(i−2)(i−1)/2 hold the partial products c·q0, c·q0·q1, …, c·q0…q(i−2), in that order, where q is `count_o`.
- R7: `cost_o` equals N + 1 + 5·N·(N−1)/2. That is 19 for N=3 and 35 for N=4.
- R8: Every gate primitive is a bijection on its control, ancilla and target lines.
- R9: A gate primitive passes its controls unchanged. It inverts its target exactly when all controls are 1. Each ancilla j is XORed with the AND of controls 0 to j+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| c_i | input | 1 | Count enable line |
| count_o | output | N | Registered count |
| garbage_o | output | 1+(N−2)(N−1)/2 | Pass-through enable line and ancilla partial products |
| cost_o | output | clog2(cost+1) | Static gate cost tally |

## Verification
The embedded properties check on every cycle that the count holds, that it increments, and that it wraps from all ones to zero. They also check that the enable line passes through to the garbage output, and that no partial product can be set while the enable is low. Some behaviour only the bench's scenarios can show. These are the exact garbage pattern for each state, the cost constant for two widths, an asynchronous reset taken in the middle of a count, and the exhaustive bijection and truth-table sweep of each gate width, with one to four controls.

// File: rtl/rev_ctr_pkg.sv
package rev_ctr_pkg;
  // Cost of a gate with k controls: 1 for k<2, else 5*(k-1)
  function automatic int gate_cost(input int k);
    return (k < 2) ? 1 : 5 * (k - 1);
  endfunction

  // Bit gates plus one copy gate per bit
  function automatic int cost_total(input int n);
    int s;
    s = 0;
    for (int i = 0; i < n; i++) s += gate_cost(i + 1) + 1;
    return s;
  endfunction

  function automatic int garb_off(input int i);
    return 1 + ((i - 2) * (i - 1)) / 2;
  endfunction

  function automatic int garb_width(input int n);
    return (n < 3) ? 1 : garb_off(n);
  endfunction
endpackage

// File: rtl/rev_mct.sv
module rev_mct #(
  parameter int N_CTRL = 2,
  localparam int ANC_W = (N_CTRL > 2) ? N_CTRL - 2 : 1
) (
  input  logic [N_CTRL-1:0] ctrl_i,
  input  logic [ANC_W-1:0]  anc_i,
  input  logic              tgt_i,
  output logic [N_CTRL-1:0] ctrl_o,
  output logic [ANC_W-1:0]  anc_o,
  output logic              tgt_o
);
  assign ctrl_o = ctrl_i;

  generate
    if (N_CTRL >= 3) begin : g_chain
      logic [N_CTRL-3:0] pp;
      assign pp[0] = ctrl_i[0] & ctrl_i[1];
      for (genvar j = 1; j <= N_CTRL - 3; j++) begin : g_pp
        assign pp[j] = pp[j-1] & ctrl_i[j+1];
      end
      assign anc_o = anc_i ^ pp;
      assign tgt_o = tgt_i ^ (pp[N_CTRL-3] & ctrl_i[N_CTRL-1]);
    end else if (N_CTRL == 2) begin : g_tof
      assign anc_o = anc_i;
      assign tgt_o = tgt_i ^ (ctrl_i[0] & ctrl_i[1]);
    end else begin : g_cnot
      assign anc_o = anc_i;
      assign tgt_o = tgt_i ^ ctrl_i[0];
    end
  endgenerate
endmodule

// File: rtl/rev_up_counter.sv
module rev_up_counter
  import rev_ctr_pkg::*;
#(
  parameter int N = 4,
  localparam int GW     = garb_width(N),
  localparam int COST   = cost_total(N),
  localparam int COST_W = $clog2(COST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              c_i,
  output logic [N-1:0]      count_o,
  output logic [GW-1:0]     garbage_o,
  output logic [COST_W-1:0] cost_o
);
  logic [N-1:0] q, nxt, cpy;

  assign garbage_o[0] = c_i;
  assign cost_o       = COST_W'(COST);

  // Controls read only present lines, equivalent to applying gates MSB first
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic cp_unused_anc;
      logic cp_unused_ctrl;
      if (i == 0) begin : g_b0
        logic unused_anc;
        logic unused_ctrl;
        rev_mct #(.N_CTRL(1)) u_gate (
          .ctrl_i(c_i), .anc_i(1'b0), .tgt_i(q[0]),
          .ctrl_o(unused_ctrl), .anc_o(unused_anc), .tgt_o(nxt[0]));
      end else if (i == 1) begin : g_b1
        logic       unused_anc;
        logic [1:0] unused_ctrl;
        rev_mct #(.N_CTRL(2)) u_gate (
          .ctrl_i({q[0], c_i}), .anc_i(1'b0), .tgt_i(q[1]),
          .ctrl_o(unused_ctrl), .anc_o(unused_anc), .tgt_o(nxt[1]));
      end else begin : g_bn
        logic [i:0] unused_ctrl;
        rev_mct #(.N_CTRL(i + 1)) u_gate (
          .ctrl_i({q[i-1:0], c_i}), .anc_i('0), .tgt_i(q[i]),
          .ctrl_o(unused_ctrl), .anc_o(garbage_o[garb_off(i) +: (i-1)]),
          .tgt_o(nxt[i]));
      end
      // Feynman copy onto a constant-0 line
      rev_mct #(.N_CTRL(1)) u_copy (
        .ctrl_i(nxt[i]), .anc_i(1'b0), .tgt_i(1'b0),
        .ctrl_o(cp_unused_ctrl), .anc_o(cp_unused_anc), .tgt_o(cpy[i]));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= cpy;
  end

  assign count_o = q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_i |=> $stable(count_o));
  assert_incr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_i |=> count_o == N'($past(count_o) + 1'b1));
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_i && &count_o) |=> count_o == '0);
  assert_c_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    garbage_o[0] == c_i);
  generate
    if (GW > 1) begin : g_ga
      assert_pp_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|garbage_o[GW-1:1]) |-> c_i);
    end
  endgenerate
endmodule

// File: tb/tb_rev_up_counter.sv
module tb_rev_up_counter;
  import rev_ctr_pkg::*;
  localparam int N    = 4;
  localparam int GW   = garb_width(N);
  localparam int CW   = $clog2(cost_total(N) + 1);
  localparam int CW3  = $clog2(cost_total(3) + 1);

  logic clk = 0, rst_ni = 0, c = 0, done = 0;
  logic [N-1:0]  count;
  logic [GW-1:0] garb;
  logic [CW-1:0] cost;
  logic [2:0]    count3;
  logic [garb_width(3)-1:0] garb3;
  logic [CW3-1:0] cost3;
  int n_chk = 0, n_fail = 0;

  always #5ns clk = ~clk;

  rev_up_counter #(.N(N)) dut (.clk_i(clk), .rst_ni(rst_ni), .c_i(c),
    .count_o(count), .garbage_o(garb), .cost_o(cost));
  rev_up_counter #(.N(3)) dut_n3 (.clk_i(clk), .rst_ni(rst_ni), .c_i(1'b0),
    .count_o(count3), .garbage_o(garb3), .cost_o(cost3));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [GW-1:0] exp_garb(input logic cc, input logic [N-1:0] q);
    logic [GW-1:0] g;
    logic p;
    g = '0;
    g[0] = cc;
    for (int i = 2; i < N; i++) begin
      p = cc;
      for (int m = 0; m <= i - 2; m++) begin
        p = p & q[m];
        g[garb_off(i) + m] = p;
      end
    end
    return g;
  endfunction

  // Exhaustive sweep of each primitive width (R8, R9)
  generate
    for (genvar k = 1; k <= 4; k++) begin : g_prim
      localparam int AW = (k > 2) ? k - 2 : 1;
      localparam int L  = k + AW + 1;
      logic [k-1:0]  ci, co;
      logic [AW-1:0] ai, ao;
      logic          ti, to;
      rev_mct #(.N_CTRL(k)) u_p (.ctrl_i(ci), .anc_i(ai), .tgt_i(ti),
        .ctrl_o(co), .anc_o(ao), .tgt_o(to));
      initial begin
        bit seen [2**L];
        int dup;
        logic [AW-1:0] ea;
        logic pp;
        dup = 0;
        for (int v = 0; v < 2**L; v++) seen[v] = 0;
        for (int v = 0; v < 2**L; v++) begin
          {ti, ai, ci} = L'(v);
          #1;
          ea = ai;
          pp = ci[0];
          for (int j = 1; j < k; j++) begin
            pp = pp & ci[j];
            if (k > 2 && j <= k - 2) ea[j-1] = ai[j-1] ^ pp;
          end
          check(co == ci && ao == ea && to == (ti ^ pp), "R9 gate function",
                int'({to, ao, co}), int'({ti ^ pp, ea, ci}));
          if (seen[int'({to, ao, co})]) dup++;
          seen[int'({to, ao, co})] = 1;
        end
        check(dup == 0, "R8 bijection", dup, 0);
      end
    end
  endgenerate

  initial begin
    logic [N-1:0] exp;
    #12ns;
    check(count == 0, "R1 reset", count, 0);
    check(cost == CW'(35), "R7 cost N=4", cost, 35);
    check(cost3 == CW3'(19), "R7 cost N=3", cost3, 19);
    check(cost == CW'(N + 1 + 5 * N * (N - 1) / 2), "R7 cost formula", cost,
          N + 1 + 5 * N * (N - 1) / 2);
    @(negedge clk); rst_ni = 1;
    exp = 0;
    // Random enable sequence, well beyond 2^(N+2) cycles
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      check(count == exp, (c ? "R3 increment" : "R2 hold"), count, exp);
      c = (t < 40) ? 1'b1 : 1'($urandom_range(0, 1));
      #1;
      check(garb[0] == c, "R5 enable line", garb[0], c);
      check(garb == exp_garb(c, count), "R6 partial products", garb, exp_garb(c, count));
      exp = c ? exp + 1'b1 : exp;
    end
    // Explicit wrap
    c = 1;
    while (count != '1) @(negedge clk);
    @(negedge clk);
    check(count == 0, "R4 wrap", count, 0);
    // Hold for several cycles
    c = 0;
    exp = count;
    repeat (5) @(negedge clk);
    check(count == exp, "R2 long hold", count, exp);
    // Asynchronous reset mid-count
    c = 1;
    repeat (3) @(negedge clk);
    check(count != 0, "R1 precondition", count, 3);
    #2ns rst_ni = 0;
    #1ns;
    check(count == 0, "R1 async reset", count, 0);
    @(negedge clk);
    check(count == 0, "R1 held in reset", count, 0);
    rst_ni = 1;
    @(negedge clk);
    check(count == 1, "R3 first after reset", count, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule